// File: doc/BRIEF.md
# Shared-Library-Aware Instruction Cache Tag and Lookup

This block holds the tags and fill control of a virtually indexed, virtually tagged instruction cache that several hardware threads share. Each request carries a thread's virtual address and its process ID. Each line records whether it is valid, which process owns it, whether it belongs to shared library code, and its virtual tag. Lines marked as library code match a lookup whatever process ID the request carries. A second process that runs the same shared routine therefore reuses the line instead of evicting it or installing a second copy.

A lookup that hits returns the line one cycle after the request and never involves address translation. A lookup that misses first sends a translation request, then a refill request using the physical line address it gets back. The refill response carries the library flag of the page. The block writes the line into the way that true LRU picks, preferring an empty way. It returns the refilled data, then accepts new requests again. Only one miss is handled at a time. A flush input invalidates every line in one cycle.

Top module: `lib_icache_tags`

## Requirements
- R1: A lookup hits only when the way is valid, its stored tag equals the address tag, and either its stored process ID equals the request's or its library flag is 1.
- R2: A hit asserts rsp_valid_o with rsp_miss_o = 0 and the line data in the cycle right after the request is accepted, and issues no translation request.
- R3: A miss raises xlat_req_o in the next cycle with the line-aligned virtual address and the request's process ID, and holds it until xlat_rsp_i. It then holds fill_req_o with the line-aligned physical address until fill_rsp_i.
- R4: The cycle after fill_rsp_i, rsp_valid_o = 1 with rsp_miss_o = 1 and rsp_data_o equal to fill_data_i. The line is installed with its library flag taken from fill_lib_i.
- R5: A line with library flag 0 does not hit for a request from a different process ID. Such a request misses and fills its own copy.
- R6: A library line that is present hits for any process ID, so it is never filled a second time, and no two ways of a set ever hit together.
- R7: A fill goes into the lowest-numbered invalid way of the set. If every way is valid, it goes into the least recently used way, where both hits and fills count as uses.
- R8: From the accepted missing request until its response, req_ready_o stays 0.
- R9: flush_i forces req_ready_o to 0 in its cycle and invalidates every line, so later lookups miss.
- R10: After reset, req_ready_o = 1, no request is outstanding, rsp_valid_o = 0, and every line is invalid.
- R11: The address bits are split from the low end: OFF_W = log2(LINE_BYTES) offset bits that the lookup ignores, then IDX_W set-index bits, then the tag. With the defaults, bits [4:0] are the offset, bits [11:5] the index and bits [31:12] the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all lines |
| req_valid_i | input | 1 | Fetch request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_vaddr_i | input | ADDR_W | Virtual fetch address |
| req_pid_i | input | PID_W | Process ID of requesting thread |
| rsp_valid_o | output | 1 | Response valid (one-cycle pulse) |
| rsp_miss_o | output | 1 | Response came from a refill |
| rsp_data_o | output | LINE_BYTES*8 | Line data |
| xlat_req_o | output | 1 | Translation request, held until answered |
| xlat_vaddr_o | output | ADDR_W | Line-aligned virtual address to translate |
| xlat_pid_o | output | PID_W | Process ID for translation |
| xlat_rsp_i | input | 1 | Translation answer valid |
| xlat_paddr_i | input | ADDR_W | Translated physical address |
| fill_req_o | output | 1 | Refill request, held until answered |
| fill_paddr_o | output | ADDR_W | Line-aligned physical address |
| fill_rsp_i | input | 1 | Refill data valid |
| fill_lib_i | input | 1 | Library flag of the page |
| fill_data_i | input | LINE_BYTES*8 | Refill line data |

## Verification
The assertions check on every cycle that at most one way hits, and that an accepted hit gives a one-cycle response with no translation request. They also check that an accepted miss starts translation, that translation and refill are never requested together, that the block stays busy while a miss is open, and that a refill answer is followed by a refill response. The bench scenarios are needed to show what depends on stored state over many requests. These are the sharing of library lines across process IDs, separate copies for private code, invalid-first and LRU victim order across a sequence of conflicting fills, and the effect of a flush.

// File: rtl/lic_pkg.sv
package lic_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XLAT = 2'd1,
    ST_FILL = 2'd2
  } lic_state_e;
endpackage

// File: rtl/lic_tag_array.sv
module lic_tag_array #(
  parameter int WAYS  = 2,
  parameter int SETS  = 128,
  parameter int IDX_W = 7,
  parameter int TAG_W = 20,
  parameter int PID_W = 2,
  parameter int WAY_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  input  logic [PID_W-1:0] lk_pid_i,
  input  logic             wr_en_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [PID_W-1:0] wr_pid_i,
  input  logic             wr_lib_i,
  output logic [WAYS-1:0]  hit_o,
  output logic [WAYS-1:0]  valid_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]  vld_q;
    logic [SETS-1:0]  lib_q;
    logic [TAG_W-1:0] tag_q [SETS];
    logic [PID_W-1:0] pid_q [SETS];
    logic             sel;

    assign sel = wr_en_i && (wr_way_i == WAY_W'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      vld_q <= '0;
      else if (flush_i) vld_q <= '0;
      else if (sel)     vld_q[wr_idx_i] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (sel) begin
        tag_q[wr_idx_i] <= wr_tag_i;
        pid_q[wr_idx_i] <= wr_pid_i;
        lib_q[wr_idx_i] <= wr_lib_i;
      end
    end

    assign valid_o[w] = vld_q[lk_idx_i];
    // shared library lines skip the process-ID compare
    assign hit_o[w] = vld_q[lk_idx_i] && (tag_q[lk_idx_i] == lk_tag_i) &&
                      ((pid_q[lk_idx_i] == lk_pid_i) || lib_q[lk_idx_i]);
  end
endmodule

// File: rtl/lic_lru.sv
module lic_lru #(
  parameter int WAYS  = 2,
  parameter int SETS  = 128,
  parameter int IDX_W = 7,
  parameter int WAY_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_en_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [IDX_W-1:0] vic_idx_i,
  input  logic [WAYS-1:0]  vic_valid_i,
  output logic [WAY_W-1:0] vic_way_o
);
  if (WAYS == 1) begin : g_dm
    logic unused_lru;
    assign unused_lru = ^{clk_i, rst_ni, touch_en_i, touch_idx_i, touch_way_i,
                          vic_idx_i, vic_valid_i};
    assign vic_way_o  = '0;
  end else begin : g_ages
    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);
    // age 0 = most recent; ages in a set stay a permutation of 0..WAYS-1
    logic [WAY_W-1:0] age_q [SETS][WAYS];
    logic [WAY_W-1:0] cur_age;

    assign cur_age = age_q[touch_idx_i][touch_way_i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            age_q[s][w] <= WAY_W'(w);
      end else if (touch_en_i) begin
        for (int w = 0; w < WAYS; w++) begin
          if (touch_way_i == WAY_W'(w))
            age_q[touch_idx_i][w] <= '0;
          else if (age_q[touch_idx_i][w] < cur_age)
            age_q[touch_idx_i][w] <= age_q[touch_idx_i][w] + 1'b1;
        end
      end
    end

    always_comb begin
      logic found;
      found     = 1'b0;
      vic_way_o = '0;
      for (int w = 0; w < WAYS; w++) begin
        if (!vic_valid_i[w] && !found) begin
          vic_way_o = WAY_W'(w);
          found     = 1'b1;
        end
      end
      if (!found) begin
        for (int w = 0; w < WAYS; w++)
          if (age_q[vic_idx_i][w] == OLDEST) vic_way_o = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/lic_data_array.sv
module lic_data_array #(
  parameter int WAYS   = 2,
  parameter int SETS   = 128,
  parameter int IDX_W  = 7,
  parameter int WAY_W  = 1,
  parameter int LINE_W = 256
) (
  input  logic              clk_i,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [WAY_W-1:0]  rd_way_i,
  output logic [LINE_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [LINE_W-1:0] wr_data_i
);
  logic [LINE_W-1:0] mem_q [SETS][WAYS];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i][wr_way_i] <= wr_data_i;
    if (rd_en_i) rd_data_o <= mem_q[rd_idx_i][rd_way_i];
  end
endmodule

// File: rtl/lib_icache_tags.sv
module lib_icache_tags
  import lic_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PID_W       = 2,
  parameter int CACHE_BYTES = 8192,
  parameter int WAYS        = 2,
  parameter int LINE_BYTES  = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    flush_i,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [ADDR_W-1:0]       req_vaddr_i,
  input  logic [PID_W-1:0]        req_pid_i,
  output logic                    rsp_valid_o,
  output logic                    rsp_miss_o,
  output logic [LINE_BYTES*8-1:0] rsp_data_o,
  output logic                    xlat_req_o,
  output logic [ADDR_W-1:0]       xlat_vaddr_o,
  output logic [PID_W-1:0]        xlat_pid_o,
  input  logic                    xlat_rsp_i,
  input  logic [ADDR_W-1:0]       xlat_paddr_i,
  output logic                    fill_req_o,
  output logic [ADDR_W-1:0]       fill_paddr_o,
  input  logic                    fill_rsp_i,
  input  logic                    fill_lib_i,
  input  logic [LINE_BYTES*8-1:0] fill_data_i
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINES  = CACHE_BYTES / LINE_BYTES;
  localparam int SETS   = LINES / WAYS;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

  lic_state_e state_q;

  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic [WAYS-1:0]  hit_way, lk_valid;
  logic             hit_any;
  logic [WAY_W-1:0] hit_idx, vic_way;
  logic             req_fire, fill_done, xlat_done;

  logic [IDX_W-1:0]        m_idx_q;
  logic [TAG_W-1:0]        m_tag_q;
  logic [PID_W-1:0]        m_pid_q;
  logic [WAY_W-1:0]        m_way_q;
  logic [ADDR_W-OFF_W-1:0] m_line_q;
  logic                    rsp_valid_q, rsp_miss_q;
  logic [LINE_W-1:0]       fill_buf_q, rd_data;

  logic                    touch_en;
  logic [IDX_W-1:0]        touch_idx;
  logic [WAY_W-1:0]        touch_way;

  logic unused_bits;
  assign unused_bits = ^{req_vaddr_i[OFF_W-1:0], xlat_paddr_i[OFF_W-1:0]};

  assign lk_idx    = req_vaddr_i[OFF_W +: IDX_W];
  assign lk_tag    = req_vaddr_i[OFF_W+IDX_W +: TAG_W];
  assign req_ready_o = (state_q == ST_IDLE) && !flush_i;
  assign req_fire  = req_valid_i && req_ready_o;
  assign xlat_done = (state_q == ST_XLAT) && xlat_rsp_i;
  assign fill_done = (state_q == ST_FILL) && fill_rsp_i;

  always_comb begin
    hit_idx = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_way[w]) hit_idx = WAY_W'(w);
  end

  lic_tag_array #(
    .WAYS(WAYS), .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W),
    .PID_W(PID_W), .WAY_W(WAY_W)
  ) u_tags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (flush_i),
    .lk_idx_i (lk_idx),
    .lk_tag_i (lk_tag),
    .lk_pid_i (req_pid_i),
    .wr_en_i  (fill_done),
    .wr_way_i (m_way_q),
    .wr_idx_i (m_idx_q),
    .wr_tag_i (m_tag_q),
    .wr_pid_i (m_pid_q),
    .wr_lib_i (fill_lib_i),
    .hit_o    (hit_way),
    .valid_o  (lk_valid)
  );

  assign hit_any   = |hit_way;
  assign touch_en  = (req_fire && hit_any) || fill_done;
  assign touch_idx = fill_done ? m_idx_q : lk_idx;
  assign touch_way = fill_done ? m_way_q : hit_idx;

  lic_lru #(
    .WAYS(WAYS), .SETS(SETS), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_en_i  (touch_en),
    .touch_idx_i (touch_idx),
    .touch_way_i (touch_way),
    .vic_idx_i   (lk_idx),
    .vic_valid_i (lk_valid),
    .vic_way_o   (vic_way)
  );

  lic_data_array #(
    .WAYS(WAYS), .SETS(SETS), .IDX_W(IDX_W), .WAY_W(WAY_W), .LINE_W(LINE_W)
  ) u_data (
    .clk_i     (clk_i),
    .rd_en_i   (req_fire && hit_any),
    .rd_idx_i  (lk_idx),
    .rd_way_i  (hit_idx),
    .rd_data_o (rd_data),
    .wr_en_i   (fill_done),
    .wr_idx_i  (m_idx_q),
    .wr_way_i  (m_way_q),
    .wr_data_i (fill_data_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      rsp_miss_q  <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      rsp_miss_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_fire) begin
          if (hit_any) rsp_valid_q <= 1'b1;
          else         state_q     <= ST_XLAT;
        end
        ST_XLAT: if (xlat_rsp_i) state_q <= ST_FILL;
        ST_FILL: if (fill_rsp_i) begin
          state_q     <= ST_IDLE;
          rsp_valid_q <= 1'b1;
          rsp_miss_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (req_fire && !hit_any) begin
      m_idx_q <= lk_idx;
      m_tag_q <= lk_tag;
      m_pid_q <= req_pid_i;
      m_way_q <= vic_way;
    end
    if (xlat_done) m_line_q   <= xlat_paddr_i[ADDR_W-1:OFF_W];
    if (fill_done) fill_buf_q <= fill_data_i;
  end

  assign xlat_req_o   = (state_q == ST_XLAT);
  assign xlat_vaddr_o = {m_tag_q, m_idx_q, {OFF_W{1'b0}}};
  assign xlat_pid_o   = m_pid_q;
  assign fill_req_o   = (state_q == ST_FILL);
  assign fill_paddr_o = {m_line_q, {OFF_W{1'b0}}};
  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_miss_o   = rsp_miss_q;
  assign rsp_data_o   = rsp_miss_q ? fill_buf_q : rd_data;
endmodule

// File: rtl/lic_checker.sv
module lic_checker #(
  parameter int WAYS = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            flush_i,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic            rsp_valid_o,
  input logic            rsp_miss_o,
  input logic            xlat_req_o,
  input logic            fill_req_o,
  input logic            fill_rsp_i,
  input logic [WAYS-1:0] hit_way_i,
  input logic            hit_any_i
);
  a_r2_hit_next_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && hit_any_i) |=> (rsp_valid_o && !rsp_miss_o && !xlat_req_o));

  a_r3_miss_starts_xlat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !hit_any_i) |=> (xlat_req_o && !rsp_valid_o));

  a_r3_xlat_fill_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xlat_req_o && fill_req_o));

  a_r4_fill_then_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && fill_rsp_i) |=> (rsp_valid_o && rsp_miss_o && !fill_req_o));

  a_r6_single_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_way_i));

  a_r8_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xlat_req_o || fill_req_o) |-> !req_ready_o);

  a_r9_flush_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !req_ready_o);
endmodule

bind lib_icache_tags lic_checker #(.WAYS(WAYS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .flush_i     (flush_i),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_miss_o  (rsp_miss_o),
  .xlat_req_o  (xlat_req_o),
  .fill_req_o  (fill_req_o),
  .fill_rsp_i  (fill_rsp_i),
  .hit_way_i   (hit_way),
  .hit_any_i   (hit_any)
);

// File: tb/sim_lib_icache_tags.sv
module sim_lib_icache_tags;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int LW = 256;

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  pid;
    logic        hit;
  } vec_t;

  // default geometry: 2 ways, 128 sets; 0x0000_1000, 0x0000_1000+0x1000k and 0x4000_2000 share set 0 (R11)
  localparam vec_t VECS [12] = '{
    '{32'h0000_1000, 2'd0, 1'b0},  // R10 empty cache misses, fills way 0
    '{32'h0000_1004, 2'd0, 1'b1},  // R11 offset ignored
    '{32'h0000_1000, 2'd1, 1'b0},  // R5 private line, other pid misses, invalid way 1 (R7)
    '{32'h0000_1000, 2'd0, 1'b1},  // R5 both private copies present
    '{32'h4000_2000, 2'd0, 1'b0},  // R7 evicts LRU way (pid1 copy)
    '{32'h4000_2010, 2'd1, 1'b1},  // R6 library line shared
    '{32'h4000_2000, 2'd3, 1'b1},  // R6 library line shared
    '{32'h0000_1000, 2'd1, 1'b0},  // R7 evicted earlier; now replaces pid0 copy
    '{32'h0000_1000, 2'd0, 1'b0},  // R7 pid0 copy was LRU victim
    '{32'h4000_2000, 2'd2, 1'b0},  // R7 library line was LRU victim
    '{32'h0000_1020, 2'd2, 1'b0},  // R11 index 1
    '{32'h0000_1020, 2'd2, 1'b1}   // R1 hit in set 1
  };

  logic          clk = 1'b0;
  logic          rst_ni, flush_i, req_valid_i;
  logic          req_ready_o, rsp_valid_o, rsp_miss_o;
  logic [AW-1:0] req_vaddr_i;
  logic [1:0]    req_pid_i;
  logic [LW-1:0] rsp_data_o;
  logic          xlat_req_o, xlat_rsp_i, fill_req_o, fill_rsp_i, fill_lib_i;
  logic [AW-1:0] xlat_vaddr_o, xlat_paddr_i, fill_paddr_o;
  logic [1:0]    xlat_pid_o;
  logic [LW-1:0] fill_data_i;

  int errors = 0, checks = 0, cyc = 0;
  int xlat_cnt = 0, fill_cnt = 0, fill_cyc = 0, xw = 0, fw = 0;
  logic [AW-1:0] last_xva, last_fpa;
  logic [1:0]    last_xpid;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lib_icache_tags u0 (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_vaddr_i(req_vaddr_i), .req_pid_i(req_pid_i),
    .rsp_valid_o(rsp_valid_o), .rsp_miss_o(rsp_miss_o), .rsp_data_o(rsp_data_o),
    .xlat_req_o(xlat_req_o), .xlat_vaddr_o(xlat_vaddr_o), .xlat_pid_o(xlat_pid_o),
    .xlat_rsp_i(xlat_rsp_i), .xlat_paddr_i(xlat_paddr_i),
    .fill_req_o(fill_req_o), .fill_paddr_o(fill_paddr_o),
    .fill_rsp_i(fill_rsp_i), .fill_lib_i(fill_lib_i), .fill_data_i(fill_data_i)
  );

  function automatic logic [AW-1:0] pa_of(input logic [AW-1:0] va);
    return (va & ~32'h1F) ^ 32'h8000_0000;
  endfunction

  function automatic logic [LW-1:0] line_of(input logic [AW-1:0] pa);
    return {8{pa ^ 32'h5A5A_0000}};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // translation responder: answers after 2 cycles of request
  initial begin
    xlat_rsp_i = 1'b0; xlat_paddr_i = '0;
    forever begin
      @(negedge clk);
      xlat_rsp_i = 1'b0;
      if (xlat_req_o) begin
        xw++;
        if (xw == 2) begin
          xw = 0; xlat_cnt++;
          last_xva = xlat_vaddr_o; last_xpid = xlat_pid_o;
          xlat_paddr_i = pa_of(xlat_vaddr_o) | 32'h0000_0011; // low bits must be dropped
          xlat_rsp_i = 1'b1;
        end
      end
    end
  end

  // refill responder: answers after 3 cycles; library pages have paddr bit 30 set
  initial begin
    fill_rsp_i = 1'b0; fill_lib_i = 1'b0; fill_data_i = '0;
    forever begin
      @(negedge clk);
      fill_rsp_i = 1'b0;
      if (fill_req_o) begin
        fw++;
        if (fw == 3) begin
          fw = 0; fill_cnt++; fill_cyc = cyc;
          last_fpa = fill_paddr_o;
          fill_lib_i = fill_paddr_o[30];
          fill_data_i = line_of(fill_paddr_o);
          fill_rsp_i = 1'b1;
        end
      end
    end
  end

  task automatic fetch(input logic [AW-1:0] va, input logic [1:0] pid, input logic exp_hit);
    int x0, waitc;
    bit busy_ok, got_hit;
    x0 = xlat_cnt;
    while (!req_ready_o) @(negedge clk);
    req_valid_i = 1'b1; req_vaddr_i = va; req_pid_i = pid;
    @(negedge clk);
    req_valid_i = 1'b0;
    got_hit = rsp_valid_o;
    busy_ok = 1'b1; waitc = 0;
    while (!rsp_valid_o && waitc < 100) begin
      if (req_ready_o) busy_ok = 1'b0;
      @(negedge clk);
      waitc++;
    end
    check(got_hit == exp_hit, "R1/R5/R6", $sformatf("hit va=%h pid=%0d", va, pid), LW'(got_hit), LW'(exp_hit));
    check(rsp_miss_o == !exp_hit, "R2/R4", "rsp_miss_o", LW'(rsp_miss_o), LW'(!exp_hit));
    check(rsp_data_o == line_of(pa_of(va)), "R2/R4", $sformatf("data va=%h", va),
          rsp_data_o, line_of(pa_of(va)));
    if (exp_hit) begin
      check(xlat_cnt == x0, "R2", "no translation on hit", LW'(xlat_cnt - x0), '0);
    end else begin
      check(xlat_cnt == x0 + 1, "R3", "one translation on miss", LW'(xlat_cnt - x0), LW'(1));
      check(last_xva == (va & ~32'h1F), "R3", "xlat vaddr", LW'(last_xva), LW'(va & ~32'h1F));
      check(last_xpid == pid, "R3", "xlat pid", LW'(last_xpid), LW'(pid));
      check(last_fpa == pa_of(va), "R3", "fill paddr", LW'(last_fpa), LW'(pa_of(va)));
      check(cyc - fill_cyc == 1, "R4", "rsp one cycle after fill", LW'(cyc - fill_cyc), LW'(1));
      check(busy_ok, "R8", "ready low during miss", LW'(busy_ok), LW'(1));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int f0;
    rst_ni = 1'b0; flush_i = 1'b0; req_valid_i = 1'b0;
    req_vaddr_i = '0; req_pid_i = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(req_ready_o == 1'b1, "R10", "req_ready_o", LW'(req_ready_o), LW'(1));
    check(rsp_valid_o == 1'b0, "R10", "rsp_valid_o", LW'(rsp_valid_o), '0);
    check(!xlat_req_o && !fill_req_o, "R10", "no outstanding request",
          LW'({xlat_req_o, fill_req_o}), '0);

    foreach (VECS[i]) fetch(VECS[i].va, VECS[i].pid, VECS[i].hit);

    // R6: library line is filled once and then hit by every pid
    f0 = fill_cnt;
    for (int p = 0; p < 4; p++) fetch(32'h4000_2000, 2'(p), 1'b1);
    check(fill_cnt == f0, "R6", "no second library fill", LW'(fill_cnt - f0), '0);

    // R9 flush
    @(negedge clk);
    flush_i = 1'b1;
    #1;
    check(req_ready_o == 1'b0, "R9", "ready low during flush", LW'(req_ready_o), '0);
    @(negedge clk);
    flush_i = 1'b0;
    fetch(32'h0000_1020, 2'd2, 1'b0);  // R9 previously present, now misses
    fetch(32'h4000_2000, 2'd1, 1'b0);  // R9 library line gone too
    fetch(32'h4000_2004, 2'd0, 1'b1);  // R6 refilled library line shared again

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule